// File: doc/BRIEF.md
# Keypad Controller Command Interpreter

This block sits behind a serial slave front end and interprets the byte stream that a host sends to a keypad and GPIO controller. A transfer begins with a start strobe that carries a direction flag. In a write transfer the first byte accepted is an opcode and every later byte is a parameter, numbered from zero. In a read transfer the block returns bytes for the opcode of the most recent write transfer, again numbered from zero, and it returns them least significant byte first.

The block holds the configuration, clock, debounce, active-time, keypad-size and three GPIO control registers (pull, direction, output state). It also keeps an interrupt status register and a sticky error register, and it drives an active-low interrupt line. Every parameter is checked against its legal range. A failed check records an error code and leaves the target register unchanged. The key FIFO and the PWM engine are neighbouring blocks. This block reads the FIFO through a head-pop and peek port, and it forwards valid PWM command bytes to the engine.

Incoming bytes use `in_valid`/`in_ready`: a byte moves on a cycle where both are high, and `in_ready` is low for the whole of a read transfer, so write bytes wait during a read. Outgoing bytes use `out_valid`/`out_ready`: `out_valid` is high for the whole of a read transfer, `out_data` is stable until the byte is taken, and each byte the host takes advances the byte index.

Top module: `keypad_cmd_ctrl`

## Requirements
- R1: After reset, status reads 0x10 (only the not-initialized flag, bit 4), the error register reads 0, `irq_n` is low, all configuration and GPIO registers are 0, `in_ready` is high and `out_valid` is low.
- R2: `irq_n` is low exactly when status is non-zero. A `key_event` pulse sets status bit 0, and `pwm_done[n]` sets status bit 5+n.
- R3: Opcode 0x82 returns status in byte 0. When that byte is taken, status clears unless bit 4 is set. An event that arrives in the same cycle stays recorded.
- R4: Opcode 0x81 stores parameter 0 as the configuration and clears status bit 4. Opcode 0x92 returns only the low four configuration bits.
- R5: An opcode outside 0x80..0x97, or equal to 0x8D, sets error bit 1 and status bit 3. The `key_overrun` input sets error bit 2 and `fifo_overflow` sets error bit 6. Error bits stay set until a reset, and opcode 0x8C returns them.
- R6: Opcode 0x90 writes the keypad size, with columns in bits 7:4 and rows in bits 3:0. Rows outside 3..12 or columns outside 3..8 set error bit 0 and status bit 3 and keep the old value. Opcode 0x91 returns the size.
- R7: Opcode 0x93 writes the clock. A value whose low two bits are 01 or 10 is a bad parameter and is not stored. Opcode 0x94 returns the upper six bits with the low two bits forced to 10.
- R8: Opcodes 0x84, 0x85 and 0x86 write pull, direction and state, low byte at parameter 0 and high byte at parameter 1. Opcodes 0x87 and 0x88 return direction and state low byte first, and any byte past the register width returns 0.
- R9: Opcode 0x8F stores the debounce byte and opcode 0x8B stores the active-time byte.
- R10: Opcode 0x83 with parameter 0xAA restores the R1 state. Any other parameter value is a bad parameter and changes nothing else.
- R11: Opcode 0x89 presents `fifo_rd_data` with `fifo_rd_idx` = 0 and pulses `fifo_pop` for each byte taken. Opcode 0x8A presents the entry at `fifo_rd_idx` = byte index without popping.
- R12: Bytes for opcodes 0x95 (parameters 0..2), 0x96 and 0x97 (parameter 0) are forwarded on `pwm_cmd_*`, with `pwm_cmd_sel` equal to the opcode's low two bits. Parameter 0 must have a non-zero channel field in bits 1:0, and for 0x95 and 0x96 an address in bits 7:2 of at most 59. A failure sets error bit 0, and no further byte of that command is forwarded.
- R13: A read transfer lowers `in_ready`, raises `out_valid` and restarts the byte index. Opcode 0x80 returns the ID parameter (default 0x23) and opcode 0x8E returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | Start of a transfer |
| xfer_write | input | 1 | Direction of the starting transfer (1 = host writes) |
| in_valid | input | 1 | Host byte valid |
| in_ready | output | 1 | Block accepts a host byte |
| in_data | input | 8 | Host byte |
| out_valid | output | 1 | Read byte available |
| out_ready | input | 1 | Host takes the read byte |
| out_data | output | 8 | Read byte |
| irq_n | output | 1 | Active-low interrupt |
| key_event | input | 1 | Key FIFO stored an event |
| key_overrun | input | 1 | Too many keys pressed |
| fifo_overflow | input | 1 | Key FIFO overflowed |
| pwm_done | input | NPWM | Script finished, per PWM channel |
| fifo_rd_idx | output | 8 | Key FIFO entry offset from head |
| fifo_rd_data | input | 8 | Key FIFO entry at that offset |
| fifo_pop | output | 1 | Remove the FIFO head |
| pwm_cmd_valid | output | 1 | Forwarded PWM command byte |
| pwm_cmd_sel | output | 2 | 01 load script, 10 start, 11 stop |
| pwm_cmd_idx | output | 2 | Parameter index of the byte |
| pwm_cmd_data | output | 8 | Parameter byte |
| cfg_q | output | 8 | Configuration register |
| clk_cfg_q | output | 8 | Clock register |
| debounce_q | output | 8 | Debounce register |
| active_q | output | 8 | Active-time register |
| kp_size_q | output | 8 | Keypad size register |
| gpio_pull_q | output | GPIO_W | GPIO pull select |
| gpio_dir_q | output | GPIO_W | GPIO direction |
| gpio_state_q | output | GPIO_W | GPIO output state |

## Verification
The range checks are driven with random keypad-size and clock bytes mixed with directed values just inside and just outside each bound. After every write, status is read and cleared, so a stored value can be told apart from a rejected one by the register output and by the fresh error flag. Random 16-bit GPIO values with distinct byte halves confirm that the bytes are ordered low first and that reads past the width return zero. Directed sequences cover the status clear rules (the not-initialized flag held, later cleared by a configuration write), the FIFO pop and peek difference, PWM forwarding with a rejected first parameter, and the soft reset key.

// File: rtl/kpc_pkg.sv
package kpc_pkg;
  localparam logic [7:0] OP_ID_RD     = 8'h80;
  localparam logic [7:0] OP_CFG_WR    = 8'h81;
  localparam logic [7:0] OP_INT_RD    = 8'h82;
  localparam logic [7:0] OP_SOFT_RST  = 8'h83;
  localparam logic [7:0] OP_PULL_WR   = 8'h84;
  localparam logic [7:0] OP_DIR_WR    = 8'h85;
  localparam logic [7:0] OP_STATE_WR  = 8'h86;
  localparam logic [7:0] OP_DIR_RD    = 8'h87;
  localparam logic [7:0] OP_STATE_RD  = 8'h88;
  localparam logic [7:0] OP_FIFO_POP  = 8'h89;
  localparam logic [7:0] OP_FIFO_PEEK = 8'h8A;
  localparam logic [7:0] OP_ACT_WR    = 8'h8B;
  localparam logic [7:0] OP_ERR_RD    = 8'h8C;
  localparam logic [7:0] OP_HOLE      = 8'h8D;
  localparam logic [7:0] OP_ROT_RD    = 8'h8E;
  localparam logic [7:0] OP_DBNC_WR   = 8'h8F;
  localparam logic [7:0] OP_SIZE_WR   = 8'h90;
  localparam logic [7:0] OP_SIZE_RD   = 8'h91;
  localparam logic [7:0] OP_CFG_RD    = 8'h92;
  localparam logic [7:0] OP_CLK_WR    = 8'h93;
  localparam logic [7:0] OP_CLK_RD    = 8'h94;
  localparam logic [7:0] OP_PWM_LOAD  = 8'h95;
  localparam logic [7:0] OP_PWM_RUN   = 8'h96;
  localparam logic [7:0] OP_PWM_HALT  = 8'h97;
  localparam logic [7:0] OP_FIRST     = 8'h80;
  localparam logic [7:0] OP_LAST      = 8'h97;

  localparam int ST_KEY    = 0;
  localparam int ST_ERR    = 3;
  localparam int ST_NOINIT = 4;
  localparam int ST_PWM0   = 5;

  localparam int ER_PARAM  = 0;
  localparam int ER_UNKNOWN = 1;
  localparam int ER_KEYOVR = 2;
  localparam int ER_FIFOOVR = 6;

  localparam logic [7:0] SOFT_RST_KEY = 8'hAA;
  localparam logic [7:0] STATUS_INIT  = 8'h10;
endpackage

// File: rtl/kpc_op_decode.sv
module kpc_op_decode
  import kpc_pkg::*;
(
  input  logic [7:0] op,
  output logic       known
);
  always_comb begin
    known = (op >= OP_FIRST) && (op <= OP_LAST) && (op != OP_HOLE);
  end
endmodule

// File: rtl/kpc_param_check.sv
module kpc_param_check
  import kpc_pkg::*;
#(
  parameter int MAX_ROWS      = 12,
  parameter int MAX_COLS      = 8,
  parameter int PWM_LAST_ADDR = 59
) (
  input  logic [7:0] op,
  input  logic [7:0] idx,
  input  logic [7:0] data,
  output logic       bad
);
  localparam logic [3:0] MIN_DIM  = 4'd3;
  localparam logic [3:0] ROW_TOP  = 4'(MAX_ROWS);
  localparam logic [3:0] COL_TOP  = 4'(MAX_COLS);
  localparam logic [5:0] ADDR_TOP = 6'(PWM_LAST_ADDR);

  logic first;
  logic chan_zero;
  logic addr_high;

  always_comb begin
    first     = (idx == 8'd0);
    chan_zero = (data[1:0] == 2'b00);
    addr_high = (data[7:2] > ADDR_TOP);
    bad       = 1'b0;
    if (first) begin
      case (op)
        OP_SIZE_WR:  bad = (data[3:0] < MIN_DIM) || (data[3:0] > ROW_TOP) ||
                           (data[7:4] < MIN_DIM) || (data[7:4] > COL_TOP);
        OP_CLK_WR:   bad = (data[1:0] == 2'b01) || (data[1:0] == 2'b10);
        OP_SOFT_RST: bad = (data != SOFT_RST_KEY);
        OP_PWM_LOAD,
        OP_PWM_RUN:  bad = chan_zero || addr_high;
        OP_PWM_HALT: bad = chan_zero;
        default:     bad = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/kpc_irq_status.sv
module kpc_irq_status
  import kpc_pkg::*;
#(
  parameter int NPWM = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            cfg_wr,
  input  logic            clr_req,
  input  logic            key_event,
  input  logic [NPWM-1:0] pwm_done,
  input  logic [7:0]      err_set,
  output logic [7:0]      status,
  output logic [7:0]      err,
  output logic            irq_n
);
  logic [7:0] base;
  logic [7:0] set_v;
  logic [7:0] st_nxt;
  logic [7:0] err_nxt;

  always_comb begin
    set_v         = '0;
    set_v[ST_KEY] = key_event;
    set_v[ST_ERR] = |err_set;
    for (int n = 0; n < NPWM; n++) begin
      set_v[ST_PWM0 + n] = pwm_done[n];
    end
    if (soft_rst) begin
      base = STATUS_INIT;
    end else if (clr_req && !status[ST_NOINIT]) begin
      base = '0;
    end else begin
      base = status;
    end
    if (cfg_wr) begin
      base[ST_NOINIT] = 1'b0;
    end
    st_nxt  = base | set_v;
    err_nxt = (soft_rst ? 8'h00 : err) | err_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= STATUS_INIT;
      err    <= '0;
    end else begin
      status <= st_nxt;
      err    <= err_nxt;
    end
  end

  assign irq_n = (status == 8'h00);
endmodule

// File: rtl/keypad_cmd_ctrl.sv
module keypad_cmd_ctrl
  import kpc_pkg::*;
#(
  parameter int          NPWM          = 3,
  parameter int          GPIO_W        = 16,
  parameter int          MAX_ROWS      = 12,
  parameter int          MAX_COLS      = 8,
  parameter int          PWM_LAST_ADDR = 59,
  parameter logic [7:0]  ID_VAL        = 8'h23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  logic              xfer_write,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              irq_n,
  input  logic              key_event,
  input  logic              key_overrun,
  input  logic              fifo_overflow,
  input  logic [NPWM-1:0]   pwm_done,
  output logic [7:0]        fifo_rd_idx,
  input  logic [7:0]        fifo_rd_data,
  output logic              fifo_pop,
  output logic              pwm_cmd_valid,
  output logic [1:0]        pwm_cmd_sel,
  output logic [1:0]        pwm_cmd_idx,
  output logic [7:0]        pwm_cmd_data,
  output logic [7:0]        cfg_q,
  output logic [7:0]        clk_cfg_q,
  output logic [7:0]        debounce_q,
  output logic [7:0]        active_q,
  output logic [7:0]        kp_size_q,
  output logic [GPIO_W-1:0] gpio_pull_q,
  output logic [GPIO_W-1:0] gpio_dir_q,
  output logic [GPIO_W-1:0] gpio_state_q
);
  localparam int GPIO_BYTES = GPIO_W / 8;

  logic       rd_phase;
  logic       have_op;
  logic       bad_seen;
  logic [7:0] op;
  logic [7:0] idx;
  logic [7:0] idx_inc;
  logic       in_acc, op_byte, par_byte, out_acc;
  logic       op_known, bad;
  logic       soft_rst, cfg_wr, clr_req, pwm_hit, pwm_in_range;
  logic [7:0] err_set;
  logic [7:0] status;
  logic [7:0] err;

  assign in_ready  = !rd_phase;
  assign out_valid = rd_phase;
  assign in_acc    = in_valid && in_ready && !xfer_start;
  assign op_byte   = in_acc && !have_op;
  assign par_byte  = in_acc && have_op;
  assign out_acc   = out_valid && out_ready && !xfer_start;
  assign idx_inc   = (idx == 8'hFF) ? idx : idx + 8'd1;

  kpc_op_decode u_decode (
    .op    (in_data),
    .known (op_known)
  );

  kpc_param_check #(
    .MAX_ROWS      (MAX_ROWS),
    .MAX_COLS      (MAX_COLS),
    .PWM_LAST_ADDR (PWM_LAST_ADDR)
  ) u_check (
    .op   (op),
    .idx  (idx),
    .data (in_data),
    .bad  (bad)
  );

  always_comb begin
    soft_rst = par_byte && (op == OP_SOFT_RST) && (idx == 8'd0) && !bad;
    cfg_wr   = par_byte && (op == OP_CFG_WR) && (idx == 8'd0);
    clr_req  = out_acc && (op == OP_INT_RD) && (idx == 8'd0);
    err_set             = '0;
    err_set[ER_PARAM]   = par_byte && bad;
    err_set[ER_UNKNOWN] = op_byte && !op_known;
    err_set[ER_KEYOVR]  = key_overrun;
    err_set[ER_FIFOOVR] = fifo_overflow;
  end

  kpc_irq_status #(.NPWM(NPWM)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .cfg_wr    (cfg_wr),
    .clr_req   (clr_req),
    .key_event (key_event),
    .pwm_done  (pwm_done),
    .err_set   (err_set),
    .status    (status),
    .err       (err),
    .irq_n     (irq_n)
  );

  // transfer framing and byte index
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_phase <= 1'b0;
      have_op  <= 1'b0;
      bad_seen <= 1'b0;
      op       <= '0;
      idx      <= '0;
    end else if (xfer_start) begin
      rd_phase <= !xfer_write;
      idx      <= '0;
      if (xfer_write) have_op <= 1'b0;
    end else begin
      if (op_byte) begin
        op       <= in_data;
        have_op  <= 1'b1;
        idx      <= '0;
        bad_seen <= 1'b0;
      end
      if (par_byte) begin
        idx <= idx_inc;
        if (bad) bad_seen <= 1'b1;
      end
      if (out_acc) idx <= idx_inc;
    end
  end

  // register bank
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q        <= '0;
      clk_cfg_q    <= '0;
      debounce_q   <= '0;
      active_q     <= '0;
      kp_size_q    <= '0;
      gpio_pull_q  <= '0;
      gpio_dir_q   <= '0;
      gpio_state_q <= '0;
    end else if (soft_rst) begin
      cfg_q        <= '0;
      clk_cfg_q    <= '0;
      debounce_q   <= '0;
      active_q     <= '0;
      kp_size_q    <= '0;
      gpio_pull_q  <= '0;
      gpio_dir_q   <= '0;
      gpio_state_q <= '0;
    end else if (par_byte && !bad) begin
      if (idx == 8'd0) begin
        case (op)
          OP_CFG_WR:  cfg_q      <= in_data;
          OP_CLK_WR:  clk_cfg_q  <= in_data;
          OP_DBNC_WR: debounce_q <= in_data;
          OP_ACT_WR:  active_q   <= in_data;
          OP_SIZE_WR: kp_size_q  <= in_data;
          default: ;
        endcase
      end
      for (int b = 0; b < GPIO_BYTES; b++) begin
        if (idx == 8'(b)) begin
          case (op)
            OP_PULL_WR:  gpio_pull_q[b*8 +: 8]  <= in_data;
            OP_DIR_WR:   gpio_dir_q[b*8 +: 8]   <= in_data;
            OP_STATE_WR: gpio_state_q[b*8 +: 8] <= in_data;
            default: ;
          endcase
        end
      end
    end
  end

  // read data selection
  always_comb begin
    out_data = '0;
    case (op)
      OP_ID_RD:     if (idx == 8'd0) out_data = ID_VAL;
      OP_INT_RD:    if (idx == 8'd0) out_data = status;
      OP_ERR_RD:    if (idx == 8'd0) out_data = err;
      OP_SIZE_RD:   if (idx == 8'd0) out_data = kp_size_q;
      OP_CFG_RD:    if (idx == 8'd0) out_data = {4'h0, cfg_q[3:0]};
      OP_CLK_RD:    if (idx == 8'd0) out_data = {clk_cfg_q[7:2], 2'b10};
      OP_FIFO_POP,
      OP_FIFO_PEEK: out_data = fifo_rd_data;
      OP_DIR_RD: begin
        for (int b = 0; b < GPIO_BYTES; b++)
          if (idx == 8'(b)) out_data = gpio_dir_q[b*8 +: 8];
      end
      OP_STATE_RD: begin
        for (int b = 0; b < GPIO_BYTES; b++)
          if (idx == 8'(b)) out_data = gpio_state_q[b*8 +: 8];
      end
      default: out_data = '0;
    endcase
  end

  assign fifo_rd_idx = (op == OP_FIFO_PEEK) ? idx : 8'd0;
  assign fifo_pop    = out_acc && (op == OP_FIFO_POP);

  // PWM command forwarding
  always_comb begin
    pwm_hit      = (op == OP_PWM_LOAD) || (op == OP_PWM_RUN) || (op == OP_PWM_HALT);
    pwm_in_range = (op == OP_PWM_LOAD) ? (idx < 8'd3) : (idx == 8'd0);
    pwm_cmd_valid = par_byte && pwm_hit && pwm_in_range && !bad && !bad_seen;
    pwm_cmd_sel   = op[1:0];
    pwm_cmd_idx   = idx[1:0];
    pwm_cmd_data  = in_data;
  end
endmodule

// File: rtl/keypad_cmd_ctrl_chk.sv
module keypad_cmd_ctrl_chk #(
  parameter int NPWM     = 3,
  parameter int GPIO_W   = 16,
  parameter int MAX_ROWS = 12,
  parameter int MAX_COLS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [7:0]        in_data,
  input logic              have_op,
  input logic [7:0]        op,
  input logic [7:0]        idx,
  input logic [7:0]        status,
  input logic [7:0]        err,
  input logic [7:0]        kp_size_q,
  input logic [GPIO_W-1:0] gpio_pull_q,
  input logic              key_event,
  input logic              key_overrun,
  input logic              fifo_overflow,
  input logic [NPWM-1:0]   pwm_done,
  input logic              out_valid,
  input logic              out_ready,
  input logic              xfer_start,
  input logic              irq_n
);
  logic acc;
  logic quiet;
  assign acc   = in_valid && in_ready && !xfer_start;
  assign quiet = !key_event && (pwm_done == '0) && !key_overrun && !fifo_overflow;

  a_r2_key_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
    key_event |=> (status[0] && !irq_n));

  a_r3_int_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !xfer_start && op == 8'h82 && idx == 8'd0 &&
     !status[4] && quiet) |=> (status == 8'h00));

  a_r4_noinit_held: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4] && !acc) |=> status[4]);

  a_r5_unknown_op: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !have_op && (in_data < 8'h80 || in_data > 8'h97 || in_data == 8'h8D))
    |=> (err[1] && status[3]));

  a_r6_bad_size_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && have_op && op == 8'h90 && idx == 8'd0 &&
     (in_data[3:0] < 4'd3 || in_data[3:0] > 4'(MAX_ROWS) ||
      in_data[7:4] < 4'd3 || in_data[7:4] > 4'(MAX_COLS)))
    |=> ($stable(kp_size_q) && err[0]));

  a_r8_gpio_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(gpio_pull_q));
endmodule

bind keypad_cmd_ctrl keypad_cmd_ctrl_chk #(
  .NPWM(NPWM), .GPIO_W(GPIO_W), .MAX_ROWS(MAX_ROWS), .MAX_COLS(MAX_COLS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .have_op(have_op), .op(op), .idx(idx),
  .status(status), .err(err), .kp_size_q(kp_size_q),
  .gpio_pull_q(gpio_pull_q), .key_event(key_event),
  .key_overrun(key_overrun), .fifo_overflow(fifo_overflow),
  .pwm_done(pwm_done), .out_valid(out_valid), .out_ready(out_ready),
  .xfer_start(xfer_start), .irq_n(irq_n)
);

// File: tb/keypad_cmd_ctrl_test.sv
`timescale 1ns/1ps
module keypad_cmd_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_start = 1'b0, xfer_write = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, out_valid, irq_n, fifo_pop;
  logic [7:0]  out_data, fifo_rd_idx, fifo_rd_data;
  logic        key_event = 1'b0, key_overrun = 1'b0, fifo_overflow = 1'b0;
  logic [2:0]  pwm_done = '0;
  logic        pwm_cmd_valid;
  logic [1:0]  pwm_cmd_sel, pwm_cmd_idx;
  logic [7:0]  pwm_cmd_data;
  logic [7:0]  cfg_q, clk_cfg_q, debounce_q, active_q, kp_size_q;
  logic [15:0] gpio_pull_q, gpio_dir_q, gpio_state_q;

  int checks = 0, fails = 0, pops = 0, pw_n = 0;
  logic [1:0] pw_sel [16];
  logic [1:0] pw_idx [16];
  logic [7:0] pw_dat [16];

  always #4 clk = ~clk;
  assign fifo_rd_data = 8'hC0 ^ fifo_rd_idx;

  keypad_cmd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_write(xfer_write),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .irq_n(irq_n), .key_event(key_event), .key_overrun(key_overrun),
    .fifo_overflow(fifo_overflow), .pwm_done(pwm_done),
    .fifo_rd_idx(fifo_rd_idx), .fifo_rd_data(fifo_rd_data), .fifo_pop(fifo_pop),
    .pwm_cmd_valid(pwm_cmd_valid), .pwm_cmd_sel(pwm_cmd_sel),
    .pwm_cmd_idx(pwm_cmd_idx), .pwm_cmd_data(pwm_cmd_data),
    .cfg_q(cfg_q), .clk_cfg_q(clk_cfg_q), .debounce_q(debounce_q),
    .active_q(active_q), .kp_size_q(kp_size_q), .gpio_pull_q(gpio_pull_q),
    .gpio_dir_q(gpio_dir_q), .gpio_state_q(gpio_state_q)
  );

  always @(posedge clk) begin
    if (fifo_pop) pops++;
    if (pwm_cmd_valid && pw_n < 16) begin
      pw_sel[pw_n] = pwm_cmd_sel;
      pw_idx[pw_n] = pwm_cmd_idx;
      pw_dat[pw_n] = pwm_cmd_data;
      pw_n++;
    end
  end

  function automatic bit size_ok(input logic [7:0] v);
    return (v[3:0] >= 3) && (v[3:0] <= 12) && (v[7:4] >= 3) && (v[7:4] <= 8);
  endfunction
  function automatic bit clk_ok(input logic [7:0] v);
    return (v[1:0] == 2'b00) || (v[1:0] == 2'b11);
  endfunction
  function automatic logic [7:0] clk_view(input logic [7:0] v);
    return {v[7:2], 2'b10};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start(input bit wr);
    xfer_start = 1'b1; xfer_write = wr;
    @(negedge clk);
    xfer_start = 1'b0;
  endtask
  task automatic put(input logic [7:0] b);
    in_valid = 1'b1; in_data = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask
  task automatic get(output logic [7:0] b);
    out_ready = 1'b1; b = out_data;
    @(negedge clk);
    out_ready = 1'b0;
  endtask
  task automatic wr1(input logic [7:0] op, input logic [7:0] d);
    start(1); put(op); put(d);
  endtask
  task automatic rd1(input logic [7:0] op, output logic [7:0] b);
    start(1); put(op); start(0); get(b);
  endtask
  task automatic pulse_key();
    key_event = 1'b1; @(negedge clk); key_event = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] b, b0, b1, b2, v, prev;
    logic [15:0] w;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq_n", irq_n, 0);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 regs", {cfg_q, clk_cfg_q, kp_size_q, gpio_dir_q}, 0);
    rd1(8'h82, b); chk("R1 status", b, 8'h10);
    rd1(8'h82, b); chk("R3 noinit not cleared", b, 8'h10);
    rd1(8'h8C, b); chk("R1 error", b, 0);

    // R13 handshake and fixed reads
    start(1); put(8'h80); start(0);
    chk("R13 in_ready low", in_ready, 0);
    chk("R13 out_valid high", out_valid, 1);
    get(b); chk("R13 id", b, 8'h23);
    start(1);
    chk("R13 out_valid low", out_valid, 0);
    rd1(8'h8E, b); chk("R13 rotator", b, 0);

    // R4 config
    wr1(8'h81, 8'h5A);
    chk("R4 cfg_q", cfg_q, 8'h5A);
    chk("R2 irq released", irq_n, 1);
    rd1(8'h92, b); chk("R4 cfg read", b, 8'h0A);

    // R2 / R3 events and clear
    pulse_key();
    chk("R2 key irq", irq_n, 0);
    rd1(8'h82, b); chk("R3 key status", b, 8'h01);
    chk("R3 cleared", irq_n, 1);
    pwm_done = 3'b100; @(negedge clk); pwm_done = 3'b000;
    rd1(8'h82, b); chk("R2 pwm2 status", b, 8'h80);
    start(1); put(8'h82); start(0);
    key_event = 1'b1; get(b); key_event = 1'b0;
    rd1(8'h82, b); chk("R3 same-cycle event kept", b, 8'h01);

    // R5 unknown and sticky errors
    start(1); put(8'h8D);
    chk("R5 unknown irq", irq_n, 0);
    rd1(8'h8C, b); chk("R5 error unknown", b, 8'h02);
    rd1(8'h82, b); chk("R5 status err", b, 8'h08);
    start(1); put(8'h42);
    key_overrun = 1'b1; @(negedge clk); key_overrun = 1'b0;
    fifo_overflow = 1'b1; @(negedge clk); fifo_overflow = 1'b0;
    rd1(8'h8C, b); chk("R5 sticky errors", b, 8'h46);
    rd1(8'h82, b);

    // R6 keypad size: directed then random
    prev = 8'h00;
    for (int i = 0; i < 30; i++) begin
      case (i)
        0: v = 8'h8C; 1: v = 8'h2C; 2: v = 8'h9C; 3: v = 8'h3D;
        4: v = 8'h33; 5: v = 8'h32;
        default: v = 8'($urandom);
      endcase
      wr1(8'h90, v);
      if (size_ok(v)) prev = v;
      chk("R6 size reg", kp_size_q, prev);
      rd1(8'h82, b); chk("R6 error flag", b, size_ok(v) ? 8'h00 : 8'h08);
      rd1(8'h91, b); chk("R6 size read", b, prev);
    end

    // R7 clock
    prev = 8'h00;
    for (int i = 0; i < 16; i++) begin
      case (i)
        0: v = 8'h01; 1: v = 8'h02; 2: v = 8'h03; 3: v = 8'hFC;
        default: v = 8'($urandom);
      endcase
      wr1(8'h93, v);
      if (clk_ok(v)) prev = v;
      chk("R7 clock reg", clk_cfg_q, prev);
      rd1(8'h82, b); chk("R7 error flag", b, clk_ok(v) ? 8'h00 : 8'h08);
      rd1(8'h94, b); chk("R7 clock read", b, clk_view(prev));
    end

    // R8 GPIO
    for (int i = 0; i < 8; i++) begin
      w = 16'($urandom);
      start(1); put(8'h84); put(w[7:0]); put(w[15:8]);
      chk("R8 pull", gpio_pull_q, w);
      w = 16'($urandom);
      start(1); put(8'h85); put(w[7:0]); put(w[15:8]);
      chk("R8 dir", gpio_dir_q, w);
      start(1); put(8'h87); start(0); get(b0); get(b1); get(b2);
      chk("R8 dir read", {b2, b1, b0}, {8'h00, w[15:8], w[7:0]});
      w = 16'($urandom);
      start(1); put(8'h86); put(w[7:0]); put(w[15:8]);
      start(1); put(8'h88); start(0); get(b0); get(b1); get(b2);
      chk("R8 state read", {b2, b1, b0}, {8'h00, w[15:8], w[7:0]});
    end

    // R9 debounce / active time
    wr1(8'h8F, 8'h3E); chk("R9 debounce", debounce_q, 8'h3E);
    wr1(8'h8B, 8'hB7); chk("R9 active", active_q, 8'hB7);

    // R11 FIFO pop and peek
    start(1); put(8'h89); start(0); get(b0); get(b1);
    chk("R11 pop data", {b0, b1}, 16'hC0C0);
    chk("R11 pop count", pops, 2);
    start(1); put(8'h8A); start(0); get(b0); get(b1); get(b2);
    chk("R11 peek data", {b0, b1, b2}, 24'hC0C1C2);
    chk("R11 peek no pop", pops, 2);

    // R12 PWM forwarding
    rd1(8'h82, b);
    wr1(8'h96, 8'h09);
    chk("R12 run forwarded", pw_n, 1);
    chk("R12 run fields", {pw_sel[0], pw_idx[0], pw_dat[0]}, {2'b10, 2'b00, 8'h09});
    start(1); put(8'h96); put(8'hF1); put(8'h01);
    chk("R12 bad addr dropped", pw_n, 1);
    rd1(8'h82, b); chk("R12 bad addr error", b, 8'h08);
    wr1(8'h97, 8'h00);
    chk("R12 bad stop dropped", pw_n, 1);
    start(1); put(8'h95); put(8'h05); put(8'h12); put(8'h34); put(8'h56);
    chk("R12 load count", pw_n, 4);
    chk("R12 load last", {pw_sel[3], pw_idx[3], pw_dat[3]}, {2'b01, 2'b10, 8'h34});

    // R10 soft reset
    wr1(8'h83, 8'h55);
    chk("R10 bad key keeps cfg", cfg_q, 8'h5A);
    rd1(8'h82, b); chk("R10 bad key error", b, 8'h08);
    wr1(8'h83, 8'hAA);
    chk("R10 cfg cleared", {cfg_q, gpio_pull_q, debounce_q}, 0);
    chk("R10 irq low", irq_n, 0);
    rd1(8'h82, b); chk("R10 status", b, 8'h10);
    rd1(8'h8C, b); chk("R10 error cleared", b, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule